// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns one 27-bit parallel pixel word per pixel clock into four serial data lanes and one forwarded clock lane for a flat-panel display link. The word carries 24 colour bits together with horizontal sync, vertical sync and data enable. Each lane sends seven bits per pixel period. The bits are spread across the lanes in a fixed order that does not follow the input bit numbering, and one slot on lane 3 carries no data. The forwarded clock lane runs at the pixel rate.

Everything runs on the 7x bit clock `clk_bit`. The pixel clock `pix_clk` reaches the block as a level that is synchronous to `clk_bit` and phase-aligned with it: it is high for four bit periods and low for three. The block locks its seven-slot frame to the rising edge of `pix_clk`. A strap input chooses whether the word is captured at the rising or the falling edge of `pix_clk`. Each captured word sits in a holding register while the previous word shifts out, so words follow each other with no gap. An active-low power-down input silences every output and drops the frame lock. When the block is integrated, that input must carry a pull-down, so that an undriven pin means powered down, and the strap must carry a pull-down, so that an open strap selects the falling edge.

Top module: `pix_serializer7`

## Requirements
- R1: Lanes 0, 1 and 2 send their slots in time order 0..6 as follows. Lane 0: TX7, TX6, TX4, TX3, TX2, TX1, TX0. Lane 1: TX18, TX15, TX14, TX13, TX12, TX9, TX8. Lane 2: TX26, TX25, TX24, TX22, TX21, TX20, TX19.
- R2: Lane 3 sends 0 in slot 0, then TX17, TX16, TX11, TX10, TX5, TX27 in slots 1..6.
- R3: `pix_word` bit p holds TX p for p from 0 to 22 and TX p+1 for p from 23 to 26 (TX23 does not exist). Every one of the 27 bits appears in exactly one lane slot.
- R4: In every pixel period that carries a word, the clock lane sends 1,1,0,0,0,1,1 in slots 0..6.
- R5: With `rise_sel`=1, the word captured is the one present in the bit cycle where `pix_clk` first reads high.
- R6: With `rise_sel`=0, the word captured is the one present in the bit cycle where `pix_clk` first reads low, four bit cycles after the rising edge.
- R7: A word captured in pixel period k, where period k starts at the bit cycle in which `pix_clk` rises, appears in slot s during bit cycle 7(k+1)+s. Consecutive words follow each other with no gap.
- R8: If `pd_n` is low in some bit cycle, all five lanes are 0 from the next bit cycle on, and they stay 0 for as long as `pd_n` stays low.
- R9: After reset or after power-down is released, all lanes, including the clock lane, stay 0 until a word captured in a full pixel period with `pd_n` high has been loaded.
- R10: While `rst_n` is low, all lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | 7x bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pd_n | input | 1 | Active-low power-down; needs an external pull-down |
| rise_sel | input | 1 | Capture edge: 1 selects rising, 0 selects falling; needs an external pull-down |
| pix_clk | input | 1 | Pixel clock level, synchronous to clk_bit, high 4 and low 3 bit cycles |
| pix_word | input | 27 | Parallel pixel word (colour, syncs, enable) |
| lane_data | output | 4 | Serial data lanes 0..3 |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
Several properties are checked on every cycle. The frame stays aligned to the rising edge of `pix_clk`. Each capture falls on the slot its edge choice dictates. The spare slot on lane 3 and the first clock-lane bit after each load hold their values. The lanes fall silent in the cycle after `pd_n` goes low, and no output appears before the first word has been armed. Other behaviour can only be shown by the bench's scenarios, because it depends on what the word holds: the exact bit scatter across the lanes (walking-one words and random words), which half-period word is taken under each edge setting (words that change in the middle of a period), the one-period latency across back-to-back words, and the point at which data comes back after a power-down placed in the middle of a period.

// File: rtl/pser_pkg.sv
`timescale 1ns/1ps
package pser_pkg;
  localparam int SLOTS  = 7;
  localparam int LANES  = 4;
  localparam int WORD_W = 27;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int NONE   = 31;
  // bit SLOTS-1 is sent first (slot 0)
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  // packed word position feeding a lane slot; TX23 is absent, so TX n>23 sits at n-1
  function automatic int src_pos(int lane, int slot);
    int r;
    r = NONE;
    case (lane)
      0: case (slot) 0: r = 7;  1: r = 6;  2: r = 4;  3: r = 3;  4: r = 2;  5: r = 1;  default: r = 0;  endcase
      1: case (slot) 0: r = 18; 1: r = 15; 2: r = 14; 3: r = 13; 4: r = 12; 5: r = 9;  default: r = 8;  endcase
      2: case (slot) 0: r = 25; 1: r = 24; 2: r = 23; 3: r = 22; 4: r = 21; 5: r = 20; default: r = 19; endcase
      default: case (slot) 0: r = NONE; 1: r = 17; 2: r = 16; 3: r = 11; 4: r = 10; 5: r = 5; default: r = 26; endcase
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pser_slot_timer.sv
`timescale 1ns/1ps
module pser_slot_timer #(
  parameter int SLOTS  = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              rise_sel,
  input  logic              pix_clk,
  output logic [SLOT_W-1:0] slot,
  output logic              cap_stb,
  output logic              load_stb
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] FALL_SLOT = SLOT_W'((SLOTS + 1) / 2);

  logic              pix_q;
  logic              locked_q, locked_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              rise, fall;

  assign rise = pix_clk & ~pix_q;
  assign fall = ~pix_clk & pix_q;

  always_comb begin
    slot_d   = slot_q;
    locked_d = locked_q;
    if (!pd_n) begin
      slot_d   = '0;
      locked_d = 1'b0;
    end else if (rise) begin
      slot_d   = SLOT_W'(1);
      locked_d = 1'b1;
    end else if (locked_q) begin
      slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q    <= 1'b0;
      locked_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      pix_q    <= pix_clk;
      locked_q <= locked_d;
      slot_q   <= slot_d;
    end
  end

  assign slot     = slot_q;
  assign cap_stb  = pd_n & (rise_sel ? rise : (fall & locked_q));
  assign load_stb = pd_n & locked_q & (slot_q == LAST_SLOT);

  // R7: once locked, every rising pixel edge meets slot 0
  a_r7_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && locked_q && pix_clk && !pix_q) |-> (slot_q == '0));
  // R5: rising-edge capture lands in slot 0
  a_r5_rise_capture_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && rise_sel) |-> (slot_q == '0));
  // R6: falling-edge capture lands in the middle slot
  a_r6_fall_capture_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && !rise_sel) |-> (slot_q == FALL_SLOT));
endmodule

// File: rtl/pser_lane_shift.sv
`timescale 1ns/1ps
module pser_lane_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SLOTS-1:0] din,
  output logic             sout
);
  logic [SLOTS-1:0] sh_q, sh_d;

  always_comb begin
    if (clr)       sh_d = '0;
    else if (load) sh_d = din;
    else           sh_d = {sh_q[SLOTS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sout = sh_q[SLOTS-1];
endmodule

// File: rtl/pix_serializer7.sv
`timescale 1ns/1ps
module pix_serializer7
  import pser_pkg::*;
(
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              rise_sel,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_clk
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [SLOT_W-1:0] slot;
  logic              cap_stb, load_stb;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              armed_q, armed_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  pser_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk      (clk_bit),
    .rst_n    (rst_i),
    .pd_n     (pd_n),
    .rise_sel (rise_sel),
    .pix_clk  (pix_clk),
    .slot     (slot),
    .cap_stb  (cap_stb),
    .load_stb (load_stb)
  );

  // holding stage: the next word waits here while the current one shifts
  always_comb begin
    hold_d  = hold_q;
    armed_d = armed_q;
    if (!pd_n) begin
      armed_d = 1'b0;
    end else if (cap_stb) begin
      hold_d  = pix_word;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_bit or negedge rst_i) begin
    if (!rst_i) begin
      hold_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      armed_q <= armed_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] din;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int POS = src_pos(l, s);
      if (POS == NONE) begin : g_spare
        assign din[SLOTS-1-s] = 1'b0;
      end else begin : g_bit
        assign din[SLOTS-1-s] = hold_q[POS] & armed_q;
      end
    end
    pser_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk   (clk_bit),
      .rst_n (rst_i),
      .clr   (~pd_n),
      .load  (load_stb),
      .din   (din),
      .sout  (lane_data[l])
    );
  end

  pser_lane_shift #(.SLOTS(SLOTS)) u_clk_shift (
    .clk   (clk_bit),
    .rst_n (rst_i),
    .clr   (~pd_n),
    .load  (load_stb),
    .din   (CLK_PATTERN & {SLOTS{armed_q}}),
    .sout  (lane_clk)
  );

  // R8: power-down silences every lane on the following cycle
  a_r8_pd_silent: assert property (@(posedge clk_bit) disable iff (!rst_i)
    !pd_n |=> (lane_data == '0 && !lane_clk));
  // R9: a load without an armed word keeps the link quiet
  a_r9_quiet_until_word: assert property (@(posedge clk_bit) disable iff (!rst_i)
    (load_stb && !armed_q) |=> (lane_data == '0 && !lane_clk));
  // R4: clock lane starts each carried frame high
  a_r4_clk_frame_start: assert property (@(posedge clk_bit) disable iff (!rst_i)
    (load_stb && armed_q) |=> lane_clk);
  // R2: lane 3 spare slot is always zero
  a_r2_spare_slot: assert property (@(posedge clk_bit) disable iff (!rst_i)
    load_stb |=> !lane_data[LANES-1]);
endmodule

// File: tb/pix_serializer7_test.sv
`timescale 1ns/1ps
module pix_serializer7_test;
  logic        clk_bit = 1'b0;
  logic        rst_n, pd_n, rise_sel, pix_clk;
  logic [26:0] pix_word;
  logic [3:0]  lane_data;
  logic        lane_clk;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk_bit = ~clk_bit;

  pix_serializer7 uut (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .rise_sel  (rise_sel),
    .pix_clk   (pix_clk),
    .pix_word  (pix_word),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  function automatic int tx_pos(int tx);
    return (tx < 23) ? tx : tx - 1;
  endfunction

  // expected lane bits for slot s, from the lane tables of R1, R2, R3
  function automatic logic [3:0] lanes_at(logic [26:0] w, int s);
    int t0[7] = '{7, 6, 4, 3, 2, 1, 0};
    int t1[7] = '{18, 15, 14, 13, 12, 9, 8};
    int t2[7] = '{26, 25, 24, 22, 21, 20, 19};
    int t3[7] = '{-1, 17, 16, 11, 10, 5, 27};
    logic [3:0] r;
    r[0] = w[tx_pos(t0[s])];
    r[1] = w[tx_pos(t1[s])];
    r[2] = w[tx_pos(t2[s])];
    r[3] = (t3[s] < 0) ? 1'b0 : w[tx_pos(t3[s])];
    return r;
  endfunction

  task automatic check(string tag, int g, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cycle %0d actual %b expected %b", tag, g, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_bit);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int last_low;
    bit cur_v;
    logic [26:0] cur_w;
    string cur_tag;
    void'($urandom(32'h0005EED7));
    rst_n = 1'b0; pd_n = 1'b0; rise_sel = 1'b1; pix_clk = 1'b0; pix_word = '0;
    repeat (3) begin
      @(negedge clk_bit);
      pix_word = $urandom; pd_n = 1'b1;
      check("R10", -1, lane_data, 4'b0);
      check("R10", -1, {3'b0, lane_clk}, 4'b0);
    end
    pd_n = 1'b0; pix_word = '0;
    @(negedge clk_bit);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_bit);
    last_low = -1; cur_v = 1'b0; cur_w = '0; cur_tag = "R9";
    for (int k = 0; k < 87; k++) begin
      logic [26:0] a, b;
      bit lo, sel;
      string tag;
      a = $urandom; b = a; lo = 1'b0; sel = 1'b1; tag = "R1";
      if (k < 10) begin sel = 1'b1; tag = "R1"; end
      else if (k < 20) begin sel = 1'b1; b = $urandom; tag = "R5"; end
      else if (k < 22) begin lo = 1'b1; sel = 1'b0; tag = "R8"; end
      else if (k < 32) begin sel = 1'b0; b = $urandom; tag = "R6"; end
      else if (k < 59) begin sel = 1'b0; a = 27'd1 << (k - 32); b = a; tag = "R3"; end
      else if (k == 59) begin sel = 1'b0; a = '1; b = a; tag = "R2"; end
      else if (k == 60) begin sel = 1'b0; a = 27'h2AAAAAA; b = a; tag = "R7"; end
      else if (k == 61) begin lo = 1'b1; sel = 1'b0; tag = "R8"; end
      else if (k < 70) begin sel = 1'b0; b = $urandom; tag = "R7"; end
      else if (k < 72) begin lo = 1'b1; sel = 1'b1; tag = "R8"; end
      else begin sel = 1'b1; b = $urandom; tag = "R5"; end
      for (int s = 0; s < 7; s++) begin
        int g;
        bit en;
        @(negedge clk_bit);
        g  = 7 * k + s;
        en = cur_v && (last_low < 7 * k);
        check(en ? cur_tag : ((last_low >= 7 * k) ? "R8" : "R9"), g, lane_data,
              en ? lanes_at(cur_w, s) : 4'b0);
        check("R4", g, {3'b0, lane_clk}, {3'b0, en && (s < 2 || s > 4)});
        if (en && s == 0) check("R2", g, {3'b0, lane_data[3]}, 4'b0);
        pix_clk  = (s < 4);
        pix_word = (s < 4) ? a : b;
        rise_sel = sel;
        pd_n     = !lo;
        if (lo) last_low = g;
      end
      cur_v   = (last_low < 7 * k);
      cur_w   = sel ? a : b;
      cur_tag = tag;
    end
    finish_run();
  end
endmodule